// File: doc/BRIEF.md
# Two-Wire Serial Bus Slave Byte Engine

This block is the slave side of a two-wire serial bus (SMBus / I2C style) with open-drain clock and data lines. It cleans both lines with a synchronizer and a three-sample majority filter. It recognises bus start and stop conditions and shifts bytes most significant bit first. It then compares the received 7-bit address against a programmable address. A companion mask decides which address bits take part in the comparison, and an optional general-call response covers the all-zero address.

Software drives the engine one byte at a time. The engine raises an interrupt flag at each byte boundary and holds the clock line low until software clears that flag. Software can choose the acknowledge for every received byte itself. Or, with hardware acknowledge selected, the engine places the configured acknowledge value on the bus by itself and flags the byte only after the acknowledge slot has finished. When the master reads, software supplies each byte on a parallel input. The engine then reports whether the master acknowledged that byte.

Top module: `smb_slave_engine`

## Requirements
- R1: A low pulse on SDA or SCL that lasts one clock cycle is filtered out. Such a pulse on SDA while SCL is high does not start a transfer, so the address clocked afterwards without a real START is neither acknowledged nor flagged.
- R2: START (SDA falling while SCL is high) begins address reception. Bits are sampled on SCL rising edges, most significant bit first, at bit periods down to 20 clock cycles. The last received byte appears on `rx_data`, with the address byte shown as {address, R/W}.
- R3: The address (bits 7..1 of the first byte) matches when every bit whose `cfg_mask` bit is 1 equals the corresponding `cfg_addr` bit. Bits whose mask bit is 0 are ignored.
- R4: With `cfg_gc_en` = 1, the address 0000000 is accepted and `gc_hit` reads 1. With `cfg_gc_en` = 0, that address is accepted only through the normal mask comparison.
- R5: An address that does not match is not acknowledged (SDA released during the ninth clock) and raises no flag. The engine then waits for the next START.
- R6: With `cfg_hw_ack` = 1, the engine drives the ninth bit from `ack_bit` (1 = ACK, SDA pulled low; 0 = NACK). If it acknowledged, it sets `flag` after the ninth SCL falling edge.
- R7: With `cfg_hw_ack` = 0, `flag` sets after the eighth SCL falling edge, before the ninth clock. After `flag_clr`, the ninth bit carries `ack_bit` and no second flag follows. A NACK ends the transfer.
- R8: While `flag` is 1, `scl_oe` holds SCL low. One `flag_clr` pulse clears `flag`, and SCL is released within two cycles.
- R9: An address R/W bit of 1 sets `tx_mode`. Each byte taken from `tx_data` when the flag is cleared is driven MSB first. A master ACK (SDA low on the ninth clock) sets `rcv_ack` = 1 and `flag`.
- R10: A master NACK after a transmitted byte leaves SDA released, raises no flag and returns the engine to idle.
- R11: A STOP or a repeated START in the middle of a byte aborts it without a flag. A repeated START goes straight to address reception.
- R12: `sda_oe` changes only while SCL is low.
- R13: With `cfg_en` = 0, the engine drives neither line and raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Clock line level seen on the bus |
| sda_i | input | 1 | Data line level seen on the bus |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| cfg_en | input | 1 | Engine enable |
| cfg_addr | input | 7 | Own slave address |
| cfg_mask | input | 7 | Per-bit compare mask, 1 = compare |
| cfg_gc_en | input | 1 | Respond to the all-zero address |
| cfg_hw_ack | input | 1 | Engine drives the ACK slot by itself |
| ack_bit | input | 1 | Acknowledge value, 1 = ACK |
| tx_data | input | 8 | Byte to send in transmit mode |
| flag_clr | input | 1 | One-cycle pulse clearing the flag |
| rx_data | output | 8 | Last received byte |
| flag | output | 1 | Byte-boundary interrupt flag |
| tx_mode | output | 1 | Current transfer is a master read |
| rcv_ack | output | 1 | Master acknowledged the last sent byte |
| gc_hit | output | 1 | Current transfer was a general call |

## Verification
Some properties are checked on every cycle. SDA only moves while the filtered clock is low. The flag only rises while the clock is low. No clock rising edge is seen while the flag is pending. A stop, a disable, or a master NACK leaves SDA released with no flag. The acknowledge polarity, the masked and general-call address decisions, and the MSB-first byte order need directed transfers, and so do the point at which the flag appears under each acknowledge mode, the rejection of a short glitch, and recovery after a mid-byte abort.

// File: rtl/smb_slave_pkg.sv
package smb_slave_pkg;
    localparam int SMB_DW    = 8;
    localparam int SMB_AW    = SMB_DW - 1;
    localparam int SMB_CNT_W = $clog2(SMB_DW + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACKO,
        ST_TX,
        ST_ACKI,
        ST_HOLD
    } eng_st_e;

    typedef enum logic [1:0] {
        NX_ACKO,
        NX_RX,
        NX_TX
    } resume_e;

    typedef struct packed {
        eng_st_e               st;
        resume_e               nx;
        logic [SMB_CNT_W-1:0]  cnt;
        logic [SMB_DW-1:0]     sh;
        logic [SMB_DW-1:0]     rx;
        logic                  is_addr;
        logic                  txm;
        logic                  gc;
        logic                  flag;
        logic                  post_flag;
        logic                  sda_drv;
        logic                  rcv_ack;
        logic                  scl_hold;
    } eng_t;
endpackage

// File: rtl/smb_glitch_filter.sv
module smb_glitch_filter #(
    parameter int SYNC = 2,
    parameter int WIN  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [SYNC-1:0] sync_d, sync_q;
    logic [WIN-1:0]  win_d, win_q;
    logic            out_d, out_q;

    function automatic logic majority(input logic [WIN-1:0] w);
        int ones;
        ones = 0;
        for (int i = 0; i < WIN; i++) ones += int'(w[i]);
        return ones > (WIN / 2);
    endfunction

    always_comb begin
        sync_d = {sync_q[SYNC-2:0], din};
        win_d  = {win_q[WIN-2:0], sync_q[SYNC-1]};
        out_d  = majority(win_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            win_q  <= '1;
            out_q  <= 1'b1;
        end else begin
            sync_q <= sync_d;
            win_q  <= win_d;
            out_q  <= out_d;
        end
    end

    assign dout = out_q;
endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic ev_rise,
    output logic ev_fall,
    output logic ev_start,
    output logic ev_stop
);
    logic scl_d, scl_q, sda_d, sda_q;

    always_comb begin
        scl_d = scl_f;
        sda_d = sda_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    assign ev_rise  = !scl_q && scl_f;
    assign ev_fall  = scl_q && !scl_f;
    assign ev_start = scl_q && scl_f && sda_q && !sda_f;
    assign ev_stop  = scl_q && scl_f && !sda_q && sda_f;
endmodule

// File: rtl/smb_addr_match.sv
module smb_addr_match #(
    parameter int AW = 7
) (
    input  logic [AW-1:0] rx_addr,
    input  logic [AW-1:0] own_addr,
    input  logic [AW-1:0] cmp_mask,
    input  logic          gc_en,
    output logic          hit_own,
    output logic          hit_gc
);
    logic [AW-1:0] bit_ok;

    generate
        for (genvar g = 0; g < AW; g++) begin : g_bit
            assign bit_ok[g] = !cmp_mask[g] || (rx_addr[g] == own_addr[g]);
        end
    endgenerate

    assign hit_own = &bit_ok;
    assign hit_gc  = gc_en && (rx_addr == '0);
endmodule

// File: rtl/smb_slave_engine.sv
module smb_slave_engine
    import smb_slave_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              cfg_en,
    input  logic [SMB_AW-1:0] cfg_addr,
    input  logic [SMB_AW-1:0] cfg_mask,
    input  logic              cfg_gc_en,
    input  logic              cfg_hw_ack,
    input  logic              ack_bit,
    input  logic [SMB_DW-1:0] tx_data,
    input  logic              flag_clr,
    output logic [SMB_DW-1:0] rx_data,
    output logic              flag,
    output logic              tx_mode,
    output logic              rcv_ack,
    output logic              gc_hit
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines, flt_lines;
    logic scl_f, sda_f;
    logic ev_rise, ev_fall, ev_start, ev_stop;
    logic hit_own, hit_gc;
    eng_t d, q;

    assign raw_lines = {scl_i, sda_i};

    generate
        for (genvar g = 0; g < NLINES; g++) begin : g_flt
            smb_glitch_filter #(.SYNC(2), .WIN(3)) u_flt (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (raw_lines[g]),
                .dout (flt_lines[g])
            );
        end
    endgenerate

    assign scl_f = flt_lines[1];
    assign sda_f = flt_lines[0];

    smb_bus_events u_ev (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (scl_f),
        .sda_f   (sda_f),
        .ev_rise (ev_rise),
        .ev_fall (ev_fall),
        .ev_start(ev_start),
        .ev_stop (ev_stop)
    );

    smb_addr_match #(.AW(SMB_AW)) u_match (
        .rx_addr (q.sh[SMB_DW-1:1]),
        .own_addr(cfg_addr),
        .cmp_mask(cfg_mask),
        .gc_en   (cfg_gc_en),
        .hit_own (hit_own),
        .hit_gc  (hit_gc)
    );

    always_comb begin
        d          = q;
        d.scl_hold = q.flag;
        if (!cfg_en) begin
            d = '0;
        end else if (ev_stop) begin
            d.st      = ST_IDLE;
            d.sda_drv = 1'b0;
        end else if (ev_start) begin
            d.st      = ST_RX;
            d.is_addr = 1'b1;
            d.cnt     = '0;
            d.sda_drv = 1'b0;
            d.txm     = 1'b0;
            d.gc      = 1'b0;
        end else begin
            unique case (q.st)
                ST_RX: begin
                    if (ev_rise) begin
                        d.sh  = {q.sh[SMB_DW-2:0], sda_f};
                        d.cnt = q.cnt + 1'b1;
                    end else if (ev_fall && q.cnt == SMB_CNT_W'(SMB_DW)) begin
                        if (q.is_addr && !(hit_own || hit_gc)) begin
                            d.st = ST_IDLE;
                        end else begin
                            d.rx = q.sh;
                            if (q.is_addr) begin
                                d.txm = q.sh[0];
                                d.gc  = hit_gc;
                            end
                            if (cfg_hw_ack) begin
                                d.sda_drv   = ack_bit;
                                d.post_flag = 1'b1;
                                d.st        = ST_ACKO;
                            end else begin
                                d.flag      = 1'b1;
                                d.post_flag = 1'b0;
                                d.nx        = NX_ACKO;
                                d.st        = ST_HOLD;
                            end
                        end
                    end
                end
                ST_ACKO: begin
                    if (ev_fall) begin
                        d.sda_drv = 1'b0;
                        if (!q.sda_drv) begin
                            d.st = ST_IDLE;
                        end else if (q.post_flag) begin
                            d.flag = 1'b1;
                            d.st   = ST_HOLD;
                            d.nx   = q.txm ? NX_TX : NX_RX;
                        end else if (q.txm) begin
                            d.sda_drv = !q.sh[SMB_DW-1];
                            d.cnt     = SMB_CNT_W'(1);
                            d.st      = ST_TX;
                        end else begin
                            d.st      = ST_RX;
                            d.cnt     = '0;
                            d.is_addr = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (ev_fall) begin
                        if (q.cnt == SMB_CNT_W'(SMB_DW)) begin
                            d.sda_drv = 1'b0;
                            d.st      = ST_ACKI;
                        end else begin
                            d.sh      = {q.sh[SMB_DW-2:0], 1'b0};
                            d.sda_drv = !q.sh[SMB_DW-2];
                            d.cnt     = q.cnt + 1'b1;
                        end
                    end
                end
                ST_ACKI: begin
                    if (ev_rise) begin
                        d.rcv_ack = !sda_f;
                    end else if (ev_fall) begin
                        if (q.rcv_ack) begin
                            d.flag = 1'b1;
                            d.st   = ST_HOLD;
                            d.nx   = NX_TX;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_HOLD: begin
                    if (flag_clr) begin
                        d.flag = 1'b0;
                        unique case (q.nx)
                            NX_ACKO: begin
                                d.sda_drv = ack_bit;
                                d.st      = ST_ACKO;
                                if (q.txm) d.sh = tx_data;
                            end
                            NX_TX: begin
                                d.sh      = tx_data;
                                d.sda_drv = !tx_data[SMB_DW-1];
                                d.cnt     = SMB_CNT_W'(1);
                                d.st      = ST_TX;
                            end
                            default: begin
                                d.st      = ST_RX;
                                d.cnt     = '0;
                                d.is_addr = 1'b0;
                            end
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign scl_oe  = q.flag || q.scl_hold;
    assign sda_oe  = q.sda_drv;
    assign rx_data = q.rx;
    assign flag    = q.flag;
    assign tx_mode = q.txm;
    assign rcv_ack = q.rcv_ack;
    assign gc_hit  = q.gc;

    assert_sda_moves_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && $past(cfg_en) && !$stable(sda_oe)) |-> !scl_f);

    assert_flag_rises_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> !scl_f);

    assert_hold_no_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flag |-> !ev_rise);

    assert_stop_releases_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && ev_stop) |=> (!sda_oe && !$rose(flag)));

    assert_off_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (!sda_oe && !flag));

    assert_nack_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && !ev_start && !ev_stop && q.st == ST_ACKI && ev_fall && !q.rcv_ack)
        |=> (!flag && !sda_oe));
endmodule

// File: tb/sim_smb_slave_engine.sv
module sim_smb_slave_engine;
    localparam int Q = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       scl_oe, sda_oe;
    logic       cfg_en = 1'b0;
    logic [6:0] cfg_addr = 7'h3A, cfg_mask = 7'h7F;
    logic       cfg_gc_en = 1'b0, cfg_hw_ack = 1'b1, ack_bit = 1'b1;
    logic [7:0] tx_data = 8'h00;
    logic       flag_clr = 1'b0;
    logic [7:0] rx_data;
    logic       flag, tx_mode, rcv_ack, gc_hit;
    wire        scl_bus = scl_m & ~scl_oe;
    wire        sda_bus = sda_m & ~sda_oe;

    int total = 0, bad = 0, sda_viol = 0;
    logic prev_oe = 1'b0;

    always #10 clk = ~clk;

    smb_slave_engine u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .cfg_en(cfg_en), .cfg_addr(cfg_addr),
        .cfg_mask(cfg_mask), .cfg_gc_en(cfg_gc_en), .cfg_hw_ack(cfg_hw_ack),
        .ack_bit(ack_bit), .tx_data(tx_data), .flag_clr(flag_clr),
        .rx_data(rx_data), .flag(flag), .tx_mode(tx_mode), .rcv_ack(rcv_ack),
        .gc_hit(gc_hit)
    );

    always @(posedge clk) begin
        #1;
        if (rst_n && (sda_oe !== prev_oe) && scl_bus) sda_viol++;
        prev_oe = sda_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_bit(input logic b, output logic r);
        sda_m = b;
        wq(Q);
        scl_m = 1'b1;
        while (scl_bus !== 1'b1) @(negedge clk);
        wq(Q);
        r = sda_bus;
        wq(Q);
        scl_m = 1'b0;
        wq(Q);
    endtask

    task automatic m_start;
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1;
        while (scl_bus !== 1'b1) @(negedge clk);
        wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic m_stop;
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1;
        while (scl_bus !== 1'b1) @(negedge clk);
        wq(Q);
        sda_m = 1'b1; wq(3 * Q);
    endtask

    task automatic m_wbyte(input logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) m_bit(v[i], r);
    endtask

    task automatic m_rbyte(output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, r);
            v[i] = r;
        end
    endtask

    task automatic clr_flag;
        flag_clr = 1'b1; @(negedge clk);
        flag_clr = 1'b0; wq(2);
    endtask

    task automatic t_reset;
        chk("R8 reset scl_oe", scl_oe, 0);
        chk("R12 reset sda_oe", sda_oe, 0);
        chk("R6 reset flag", flag, 0);
    endtask

    task automatic t_hw_write;
        logic r;
        cfg_hw_ack = 1'b1; ack_bit = 1'b1; cfg_mask = 7'h7F;
        m_start; m_wbyte({7'h3A, 1'b0}); m_bit(1'b1, r);
        chk("R6 hw ack on address", r, 0);
        wq(10);
        chk("R6 flag after ninth clock", flag, 1);
        chk("R8 stretch while flagged", scl_oe, 1);
        chk("R2 address byte on rx_data", rx_data, 8'h74);
        chk("R9 write keeps tx_mode low", tx_mode, 0);
        chk("R4 no general call", gc_hit, 0);
        clr_flag;
        chk("R8 released after clear", scl_oe, 0);
        m_wbyte(8'hA5); m_bit(1'b1, r);
        chk("R6 hw ack on data", r, 0);
        wq(10);
        chk("R2 data byte MSB first", rx_data, 8'hA5);
        clr_flag;
        m_wbyte(8'h3C); m_bit(1'b1, r); wq(10);
        chk("R2 second data byte", rx_data, 8'h3C);
        clr_flag; m_stop;
    endtask

    task automatic t_mask;
        logic r;
        cfg_mask = 7'h70;
        m_start; m_wbyte({7'h35, 1'b0}); m_bit(1'b1, r);
        chk("R3 masked bits ignored", r, 0);
        wq(10); clr_flag; m_stop;
        m_start; m_wbyte({7'h4A, 1'b0}); m_bit(1'b1, r);
        chk("R5 compared bit differs -> nack", r, 1);
        wq(10);
        chk("R5 no flag on miss", flag, 0);
        m_stop;
        cfg_mask = 7'h7F;
    endtask

    task automatic t_gc;
        logic r;
        cfg_gc_en = 1'b1;
        m_start; m_wbyte(8'h00); m_bit(1'b1, r);
        chk("R4 general call acked", r, 0);
        wq(10);
        chk("R4 gc_hit set", gc_hit, 1);
        clr_flag; m_stop;
        cfg_gc_en = 1'b0;
        m_start; m_wbyte(8'h00); m_bit(1'b1, r);
        chk("R4 general call off -> nack", r, 1);
        m_stop;
    endtask

    task automatic t_sw_ack;
        logic r;
        cfg_hw_ack = 1'b0; ack_bit = 1'b0;
        m_start; m_wbyte({7'h3A, 1'b0}); wq(10);
        chk("R7 flag before ninth clock", flag, 1);
        chk("R7 sda not driven yet", sda_oe, 0);
        ack_bit = 1'b1; clr_flag;
        m_bit(1'b1, r);
        chk("R7 software ack", r, 0);
        wq(10);
        chk("R7 no second flag", flag, 0);
        m_wbyte(8'h96); wq(10);
        chk("R7 data flag", flag, 1);
        chk("R7 data byte", rx_data, 8'h96);
        ack_bit = 1'b0; clr_flag;
        m_bit(1'b1, r);
        chk("R7 software nack", r, 1);
        m_stop;
        cfg_hw_ack = 1'b1; ack_bit = 1'b1;
    endtask

    task automatic t_transmit;
        logic r;
        logic [7:0] v;
        m_start; m_wbyte({7'h3A, 1'b1}); m_bit(1'b1, r);
        chk("R9 read address acked", r, 0);
        wq(10);
        chk("R9 tx_mode set", tx_mode, 1);
        tx_data = 8'hC6; clr_flag;
        m_rbyte(v);
        chk("R9 first byte sent", v, 8'hC6);
        m_bit(1'b0, r); wq(10);
        chk("R9 flag on master ack", flag, 1);
        chk("R9 rcv_ack", rcv_ack, 1);
        tx_data = 8'h5B; clr_flag;
        m_rbyte(v);
        chk("R9 second byte sent", v, 8'h5B);
        m_bit(1'b1, r); wq(10);
        chk("R10 no flag on master nack", flag, 0);
        chk("R10 sda released", sda_oe, 0);
        m_stop;
    endtask

    task automatic t_abort;
        logic r;
        m_start; m_wbyte({7'h3A, 1'b0}); m_bit(1'b1, r); wq(10); clr_flag;
        for (int i = 0; i < 4; i++) m_bit(1'b1, r);
        m_stop; wq(10);
        chk("R11 stop mid byte no flag", flag, 0);
        m_start; m_wbyte({7'h3A, 1'b0}); m_bit(1'b1, r); wq(10); clr_flag;
        for (int i = 0; i < 3; i++) m_bit(1'b0, r);
        m_start; wq(10);
        chk("R11 restart no flag", flag, 0);
        m_wbyte({7'h3A, 1'b0}); m_bit(1'b1, r);
        chk("R11 restart address acked", r, 0);
        wq(10); clr_flag; m_stop;
    endtask

    task automatic t_glitch;
        logic r;
        logic got;
        got = 1'b0;
        sda_m = 1'b0; @(negedge clk); sda_m = 1'b1; wq(3 * Q);
        scl_m = 1'b0; wq(Q);
        for (int i = 7; i >= 0; i--) begin
            m_bit(((8'h74 >> i) & 8'h01) != 0, r);
        end
        m_bit(1'b1, r);
        got = r;
        wq(10);
        chk("R1 glitch is no start", got, 1);
        chk("R1 no flag after glitch", flag, 0);
        m_stop;
    endtask

    task automatic t_disabled;
        logic r;
        cfg_en = 1'b0;
        m_start; m_wbyte({7'h3A, 1'b0}); m_bit(1'b1, r);
        chk("R13 disabled no ack", r, 1);
        wq(10);
        chk("R13 disabled no flag", flag, 0);
        m_stop;
        cfg_en = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wq(4);
        t_reset;
        rst_n = 1'b1; cfg_en = 1'b1; wq(10);
        t_hw_write;
        t_mask;
        t_gc;
        t_sw_ack;
        t_transmit;
        t_abort;
        t_glitch;
        t_disabled;
        chk("R12 sda_oe only moves with scl low", sda_viol, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule